// File: doc/BRIEF.md
# Condition Register Logic Unit

This block holds a 32-bit condition register, split into eight 4-bit fields, together with the small execution path that acts on it. One command is accepted per clock. A command can do one of four things: load the whole word, copy one field to another field, move the top nibble of an external exception register into a field, or combine two single bits of the register with a logic function and write the result to a third bit. The register's value is always visible on a combinational read port.

Bits and fields are numbered from the most significant end. Bit index 0 is vector bit 31, and field index 0 is bits 31..28. The exception register lives outside the block. It enters on `exc_in` and leaves on `exc_out`, and during a transfer command the block clears the four bits it has taken.

Commands use a valid/ready pair. `cmd_ready` is low only while `rst` is high. A command is taken on a rising edge where both `cmd_valid` and `cmd_ready` are high. There is no internal queue, so back-pressure exists only during reset. A source that holds `cmd_valid` through reset has its command taken on the first edge after reset is released.

Top module: `crlu_top`

## Requirements
- R1: On a rising edge with `rst` high the register becomes 0x00000000. `cmd_ready` is 0 while `rst` is high and 1 otherwise.
- R2: Opcode 4'h1 (move in) loads `cmd_word` into the register on the accepting edge. `cr_out` reflects the register combinationally, so a word loaded and then read back is unchanged.
- R3: Opcode 4'h2 (field copy) writes the field selected by `cmd_a[2:0]` into the field selected by `cmd_d[2:0]`. Field k occupies bits 31-4k down to 28-4k. Example: copying field 0 to field 4 of 0x01234567 gives 0x01230567.
- R4: Opcode 4'h3 (exception transfer) writes `exc_in[31:28]` into the field selected by `cmd_d[2:0]`. Example: 0xA0000000 into field 1 gives field 1 = 0xA.
- R5: `exc_out` equals `exc_in` with bits 31..28 forced to 0 while an exception-transfer command is being accepted. Otherwise `exc_out` equals `exc_in`. Bits 27..0 always pass through unchanged.
- R6: Opcodes 4'h8..4'hF are bit operations on bit A = `cmd_a`, bit B = `cmd_b`, written to bit `cmd_d`. The functions are: 8 AND, 9 A AND NOT B, A OR, B A OR NOT B, C XOR, D NAND, E NOR, F XNOR. Bit index i is vector bit 31-i.
- R7: A bit operation or field write leaves every other bit unchanged. When the target is also a source, the old value is used as the source.
- R8: When no command is accepted the register holds its value. A command that is accepted but has opcode 4'h0 or 4'h4..4'h7 also leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken (low during reset) |
| cmd_op | input | 4 | Opcode |
| cmd_a | input | 5 | Source bit A index, or source field index in bits 2..0 |
| cmd_b | input | 5 | Source bit B index |
| cmd_d | input | 5 | Target bit index, or target field index in bits 2..0 |
| cmd_word | input | 32 | Word for move in |
| exc_in | input | 32 | Exception register value in |
| exc_out | output | 32 | Exception register value out |
| cr_out | output | 32 | Current register value |

## Verification
Register updates from an accepted command appear on `cr_out` one cycle after the command is presented. The bench therefore drives each command just after a falling edge, then samples `cr_out` one time unit after the next rising edge and again at every falling edge. `exc_out` is combinational, so it is checked in the same cycle the transfer command is presented, before that command's clock edge. A behavioural model kept in the bench advances once per accepted command, and `cr_out` is compared with it on every clock.

// File: rtl/crlu_pkg.sv
package crlu_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'h0,
    OP_MOVE_IN  = 4'h1,
    OP_FCOPY    = 4'h2,
    OP_EXC_XFER = 4'h3,
    OP_AND      = 4'h8,
    OP_ANDC     = 4'h9,
    OP_OR       = 4'hA,
    OP_ORC      = 4'hB,
    OP_XOR      = 4'hC,
    OP_NAND     = 4'hD,
    OP_NOR      = 4'hE,
    OP_EQV      = 4'hF
  } crlu_op_e;

  // bit operations share opcode bit 3; low three bits select the function
  function automatic logic op_is_bitop(input logic [3:0] op);
    return op[3];
  endfunction
endpackage

// File: rtl/crlu_bitop.sv
module crlu_bitop #(
  parameter int CR_W  = 32,
  parameter int IDX_W = $clog2(CR_W)
) (
  input  logic [CR_W-1:0]  cr,
  input  logic [IDX_W-1:0] idx_a,
  input  logic [IDX_W-1:0] idx_b,
  input  logic [2:0]       fn,
  output logic             res
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(CR_W - 1);

  logic [IDX_W-1:0] pos_a, pos_b;
  logic             va, vb;

  // index 0 addresses the most significant bit
  assign pos_a = TOP - idx_a;
  assign pos_b = TOP - idx_b;
  assign va    = cr[pos_a];
  assign vb    = cr[pos_b];

  always_comb begin
    unique case (fn)
      3'd0: res = va & vb;
      3'd1: res = va & ~vb;
      3'd2: res = va | vb;
      3'd3: res = va | ~vb;
      3'd4: res = va ^ vb;
      3'd5: res = ~(va & vb);
      3'd6: res = ~(va | vb);
      default: res = ~(va ^ vb);
    endcase
  end

  // R6: with both sources on the same bit, xnor and or-complement give 1 and xor gives 0
  always_comb begin
    if (idx_a == idx_b && (fn == 3'd7 || fn == 3'd3))
      assert_same_src_one_R6: assert (res == 1'b1);
    if (idx_a == idx_b && fn == 3'd4)
      assert_same_src_zero_R6: assert (res == 1'b0);
  end
endmodule

// File: rtl/crlu_fieldsrc.sv
module crlu_fieldsrc #(
  parameter int CR_W   = 32,
  parameter int FLD_W  = 4,
  parameter int N_FLD  = CR_W / FLD_W,
  parameter int FIDX_W = $clog2(N_FLD)
) (
  input  logic [CR_W-1:0]   cr,
  input  logic [FIDX_W-1:0] src_fld,
  input  logic [FLD_W-1:0]  exc_top,
  input  logic              use_exc,
  output logic [FLD_W-1:0]  nib
);
  logic [FLD_W-1:0] fld [N_FLD];

  // field 0 is the most significant nibble
  for (genvar g = 0; g < N_FLD; g++) begin : g_split
    assign fld[g] = cr[(N_FLD-1-g)*FLD_W +: FLD_W];
  end

  assign nib = use_exc ? exc_top : fld[src_fld];
endmodule

// File: rtl/crlu_store.sv
module crlu_store #(
  parameter int CR_W   = 32,
  parameter int FLD_W  = 4,
  parameter int N_FLD  = CR_W / FLD_W,
  parameter int FIDX_W = $clog2(N_FLD),
  parameter int IDX_W  = $clog2(CR_W),
  parameter int LOW_W  = $clog2(FLD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_all,
  input  logic [CR_W-1:0]   word,
  input  logic              fld_we,
  input  logic [FIDX_W-1:0] fld_tgt,
  input  logic [FLD_W-1:0]  fld_nib,
  input  logic              bit_we,
  input  logic [IDX_W-1:0]  bit_tgt,
  input  logic              bit_val,
  output logic [CR_W-1:0]   cr_q
);
  localparam logic [LOW_W-1:0] LOW_TOP = LOW_W'(FLD_W - 1);

  logic [FIDX_W-1:0] bit_fld;
  logic [LOW_W-1:0]  bit_pos;

  assign bit_fld = bit_tgt[IDX_W-1 -: FIDX_W];
  assign bit_pos = LOW_TOP - bit_tgt[LOW_W-1:0];

  for (genvar g = 0; g < N_FLD; g++) begin : g_fld
    logic [FLD_W-1:0] q;
    logic             hit_f, hit_b;
    assign hit_f = fld_we && (fld_tgt == FIDX_W'(g));
    assign hit_b = bit_we && (bit_fld == FIDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (load_all)
        q <= word[(N_FLD-1-g)*FLD_W +: FLD_W];
      else if (hit_f)
        q <= fld_nib;
      else if (hit_b)
        q[bit_pos] <= bit_val;
    end

    assign cr_q[(N_FLD-1-g)*FLD_W +: FLD_W] = q;
  end

  // field mask used only by the checks below
  logic [CR_W-1:0] fmask;
  assign fmask = {{FLD_W{1'b1}}, {(CR_W-FLD_W){1'b0}}} >> (int'(fld_tgt) * FLD_W);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> cr_q == '0);

  assert_move_in_R2: assert property (@(posedge clk) disable iff (rst)
    load_all |=> cr_q == $past(word));

  assert_field_only_R7: assert property (@(posedge clk) disable iff (rst)
    (fld_we && !load_all) |=> ((cr_q ^ $past(cr_q)) & ~$past(fmask)) == '0);

  assert_one_bit_R7: assert property (@(posedge clk) disable iff (rst)
    (bit_we && !load_all && !fld_we) |=> $countones(cr_q ^ $past(cr_q)) <= 1);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!load_all && !fld_we && !bit_we) |=> $stable(cr_q));
endmodule

// File: rtl/crlu_top.sv
module crlu_top
  import crlu_pkg::*;
#(
  parameter int CR_W  = 32,
  parameter int FLD_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [3:0]                cmd_op,
  input  logic [$clog2(CR_W)-1:0]   cmd_a,
  input  logic [$clog2(CR_W)-1:0]   cmd_b,
  input  logic [$clog2(CR_W)-1:0]   cmd_d,
  input  logic [CR_W-1:0]           cmd_word,
  input  logic [CR_W-1:0]           exc_in,
  output logic [CR_W-1:0]           exc_out,
  output logic [CR_W-1:0]           cr_out
);
  localparam int N_FLD  = CR_W / FLD_W;
  localparam int FIDX_W = $clog2(N_FLD);
  localparam int IDX_W  = $clog2(CR_W);

  logic             acc;
  logic             is_move, is_copy, is_xfer, is_bit;
  logic [FLD_W-1:0] nib;
  logic             bit_res;

  assign cmd_ready = ~rst;
  assign acc       = cmd_valid & cmd_ready;
  assign is_move   = acc && (cmd_op == OP_MOVE_IN);
  assign is_copy   = acc && (cmd_op == OP_FCOPY);
  assign is_xfer   = acc && (cmd_op == OP_EXC_XFER);
  assign is_bit    = acc && op_is_bitop(cmd_op);

  // the transfer takes the top nibble and returns it cleared
  assign exc_out = is_xfer ? {{FLD_W{1'b0}}, exc_in[CR_W-FLD_W-1:0]} : exc_in;

  crlu_fieldsrc #(.CR_W(CR_W), .FLD_W(FLD_W)) u_fsrc (
    .cr      (cr_out),
    .src_fld (cmd_a[FIDX_W-1:0]),
    .exc_top (exc_in[CR_W-1 -: FLD_W]),
    .use_exc (is_xfer),
    .nib     (nib)
  );

  crlu_bitop #(.CR_W(CR_W)) u_bop (
    .cr    (cr_out),
    .idx_a (cmd_a),
    .idx_b (cmd_b),
    .fn    (cmd_op[2:0]),
    .res   (bit_res)
  );

  crlu_store #(.CR_W(CR_W), .FLD_W(FLD_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .load_all (is_move),
    .word     (cmd_word),
    .fld_we   (is_copy | is_xfer),
    .fld_tgt  (cmd_d[FIDX_W-1:0]),
    .fld_nib  (nib),
    .bit_we   (is_bit),
    .bit_tgt  (cmd_d[IDX_W-1:0]),
    .bit_val  (bit_res),
    .cr_q     (cr_out)
  );

  function automatic logic [FLD_W-1:0] field_of(input logic [CR_W-1:0] w,
                                                input logic [FIDX_W-1:0] f);
    return w[(N_FLD-1-int'(f))*FLD_W +: FLD_W];
  endfunction

  assert_ready_in_reset_R1: assert property (@(posedge clk)
    rst |-> !cmd_ready);

  assert_copy_field_R3: assert property (@(posedge clk) disable iff (rst)
    is_copy |=> field_of(cr_out, $past(cmd_d[FIDX_W-1:0]))
               == field_of($past(cr_out), $past(cmd_a[FIDX_W-1:0])));

  assert_xfer_field_R4: assert property (@(posedge clk) disable iff (rst)
    is_xfer |=> field_of(cr_out, $past(cmd_d[FIDX_W-1:0]))
               == $past(exc_in[CR_W-1 -: FLD_W]));

  assert_xfer_clears_R5: assert property (@(posedge clk) disable iff (rst)
    is_xfer |-> (exc_out[CR_W-1 -: FLD_W] == '0 &&
                 exc_out[CR_W-FLD_W-1:0] == exc_in[CR_W-FLD_W-1:0]));

  assert_exc_pass_R5: assert property (@(posedge clk) disable iff (rst)
    !is_xfer |-> exc_out == exc_in);

  assert_bad_op_R8: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op[3:2] == 2'b01) |=> $stable(cr_out));
endmodule

// File: tb/sim_crlu_top.sv
module sim_crlu_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1, v = 1'b0;
  logic [3:0]  op = 4'h0;
  logic [4:0]  a = '0, b = '0, d = '0;
  logic [31:0] word = '0, xin = '0;
  logic        rdy;
  logic [31:0] xout, cr;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] model = '0;
  string cur_tag = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crlu_top u0 (
    .clk(clk), .rst(rst), .cmd_valid(v), .cmd_ready(rdy), .cmd_op(op),
    .cmd_a(a), .cmd_b(b), .cmd_d(d), .cmd_word(word), .exc_in(xin),
    .exc_out(xout), .cr_out(cr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_next(input logic [31:0] m, input logic [3:0] o,
      input int ia, input int ib, input int id, input logic [31:0] w, input logic [31:0] x);
    logic [31:0] r = m;
    logic ba, bb, res;
    int fs, fd;
    fs = ia % 8; fd = id % 8;
    case (o)
      4'h1: r = w;
      4'h2: for (int k = 0; k < 4; k++) r[31 - 4*fd - k] = m[31 - 4*fs - k];
      4'h3: for (int k = 0; k < 4; k++) r[31 - 4*fd - k] = x[31 - k];
      default: begin
        if (o >= 4'h8) begin
          ba = m[31 - ia]; bb = m[31 - ib];
          case (o)
            4'h8: res = ba && bb;
            4'h9: res = ba && !bb;
            4'hA: res = ba || bb;
            4'hB: res = ba || !bb;
            4'hC: res = ba != bb;
            4'hD: res = !(ba && bb);
            4'hE: res = !(ba || bb);
            default: res = ba == bb;
          endcase
          r[31 - id] = res;
        end
      end
    endcase
    return r;
  endfunction

  // drive after a falling edge, check exc path at once, register after the rising edge
  task automatic issue(input string tag, input logic valid, input logic [3:0] o,
      input int ia, input int ib, input int id, input logic [31:0] w, input logic [31:0] x);
    logic [31:0] nxt;
    @(negedge clk);
    cur_tag = tag;
    v = valid; op = o; a = 5'(ia); b = 5'(ib); d = 5'(id); word = w; xin = x;
    #1;
    check({tag, " ready"}, {31'b0, rdy}, 32'd1);
    check({tag, " exc_out R5"}, xout, (valid && o == 4'h3) ? (x & 32'h0FFF_FFFF) : x);
    nxt = valid ? ref_next(model, o, ia, ib, id, w, x) : model;
    @(posedge clk);
    #1;
    model = nxt;
    v = 1'b0;
    check(tag, cr, model);
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) check({cur_tag, " per-cycle"}, cr, model);
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state and ready
    repeat (3) @(negedge clk);
    check("R1 ready low", {31'b0, rdy}, 32'd0);
    check("R1 reset value", cr, 32'h0);
    rst = 1'b0;

    // R2: move in / read back
    issue("R2 aaaa", 1, 4'h1, 0, 0, 0, 32'hAAAA_AAAA, 0);
    check("R2 lit", cr, 32'hAAAA_AAAA);
    issue("R2 5555", 1, 4'h1, 0, 0, 0, 32'h5555_5555, 0);
    check("R2 lit", cr, 32'h5555_5555);

    // R3: field copy
    issue("R3 load", 1, 4'h1, 0, 0, 0, 32'h0123_4567, 0);
    issue("R3 f0->f4", 1, 4'h2, 0, 0, 4, 0, 0);
    check("R3 lit", cr, 32'h0123_0567);
    issue("R3 load", 1, 4'h1, 0, 0, 0, 32'h0123_4567, 0);
    issue("R3 f7->f0", 1, 4'h2, 7, 0, 0, 0, 0);
    check("R3 lit", cr, 32'h7123_4567);

    // R4/R5: exception transfer
    issue("R4 clr", 1, 4'h1, 0, 0, 0, 32'h0, 0);
    issue("R4 xfer f1", 1, 4'h3, 0, 0, 1, 0, 32'hA000_0000);
    check("R4 lit", cr, 32'h0A00_0000);
    issue("R4 xfer f5", 1, 4'h3, 0, 0, 5, 0, 32'h4123_4567);
    check("R4 lit", cr, 32'h0A00_0400);
    issue("R5 pass", 1, 4'h2, 1, 0, 7, 0, 32'hF000_0001);

    // R6: each function on 0x0000FFFF, target bit 0
    begin
      int tv [16][4] = '{
        '{8, 0, 16, 0}, '{8, 16, 17, 1}, '{9, 0, 16, 0}, '{9, 16, 0, 1},
        '{10, 0, 16, 1}, '{10, 0, 1, 0}, '{11, 0, 16, 0}, '{11, 0, 0, 1},
        '{12, 0, 0, 0}, '{12, 0, 16, 1}, '{13, 0, 16, 1}, '{13, 16, 17, 0},
        '{14, 0, 16, 0}, '{14, 0, 1, 1}, '{15, 0, 0, 1}, '{15, 0, 16, 0}};
      for (int i = 0; i < 16; i++) begin
        issue("R6 load", 1, 4'h1, 0, 0, 0, 32'h0000_FFFF, 0);
        issue("R6 bitop", 1, 4'(tv[i][0]), tv[i][1], tv[i][2], 0, 0, 0);
        check("R6 lit", cr, tv[i][3] != 0 ? 32'h8000_FFFF : 32'h0000_FFFF);
      end
    end

    // R7: target equals source; other bits intact
    issue("R7 load", 1, 4'h1, 0, 0, 0, 32'h0000_FFFF, 0);
    issue("R7 xor self", 1, 4'hC, 16, 16, 16, 0, 0);
    check("R7 lit", cr, 32'h0000_7FFF);
    issue("R7 nor self", 1, 4'hE, 31, 31, 31, 0, 0);
    check("R7 lit", cr, 32'h0000_7FFE);

    // R8: idle, invalid opcodes, valid low
    issue("R8 valid low", 0, 4'h1, 0, 0, 0, 32'h1234_5678, 32'hF000_0000);
    check("R8 lit", cr, 32'h0000_7FFE);
    issue("R8 op5", 1, 4'h5, 3, 4, 5, 32'h1234_5678, 0);
    issue("R8 op0", 1, 4'h0, 3, 4, 5, 32'h1234_5678, 0);
    check("R8 lit", cr, 32'h0000_7FFE);

    // mixed sweep
    for (int i = 0; i < 600; i++) begin
      logic [3:0] o;
      o = 4'($urandom % 16);
      issue("R6 R7 sweep", ($urandom % 5) != 0, o, int'($urandom % 32),
            int'($urandom % 32), int'($urandom % 32), $urandom, $urandom);
    end

    // R1: reset mid-run
    issue("R1 load", 1, 4'h1, 0, 0, 0, 32'hDEAD_BEEF, 0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    model = '0;
    check("R1 ready in reset", {31'b0, rdy}, 32'd0);
    check("R1 mid reset", cr, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    issue("R1 after", 1, 4'h1, 0, 0, 0, 32'h0F0F_0F0F, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule